// File: doc/BRIEF.md
# Line-21 Caption Capture and Serial Readout Port

This block sits between a caption data slicer and a host controller. It counts scan lines from the start of each field and raises a capture window, the line-21 pulse, for the whole of the configured caption line. Whether the window opens in every field or only in even fields depends on a mode input. While the window is open, the slicer delivers each 16-bit decoded word on a parallel port with a valid strobe, and the block keeps the most recent one. When the window closes, the word moves into an output buffer, provided the host is not reading at that moment.

The host reads the buffer serially. It pulls its read enable low and clocks out 16 bits, least significant first, on its own serial clock. The data pin is driven only while the enable is low. A completed 16-bit read empties the buffer, so a second read before fresh data arrives returns all zeros, and the host can tell that the data is stale. A status output carries either an external sync-present flag or the parity of the current field, so the host can sample field parity when it sees the line-21 pulse rise. All inputs, including the host's enable and serial clock, are sampled on the block clock.

Top module: `cc_capture_port`

## Requirements
- R1: After reset, `line21_pulse` is low, `rd_sdo_oe` is low, and a 16-bit read returns 0x0000.
- R2: `rd_sdo_oe` is high exactly while `rd_en_n` is low. `rd_sdo` is low whenever `rd_en_n` is high.
- R3: With `both_fields` = 0, a field whose `field_is_odd` was 0 at its `field_tick` raises `line21_pulse` on the `line_tick` that starts line CAP_LINE (the CAP_LINE-th tick after `field_tick`). The pulse falls on the next `line_tick`. A field with `field_is_odd` = 1 raises no pulse.
- R4: With `both_fields` = 1, the pulse of R3 is raised in both odd and even fields.
- R5: A `cap_data` word strobed by `cap_valid` while `line21_pulse` is high is held, and the last strobe in the window wins. A strobe while the pulse is low is ignored.
- R6: On the falling edge of `line21_pulse`, a word held under R5 moves into the output buffer, provided `rd_en_n` is high.
- R7: If `rd_en_n` is low when the pulse falls, the held word is discarded. The buffer does not change while `rd_en_n` is low, except for the clear described in R9.
- R8: When `rd_en_n` falls, the buffer is copied for shifting and bit 0 appears on `rd_sdo`. After k falling edges of `rd_sclk`, bit k is shown (least significant bit first).
- R9: The 16th falling edge of `rd_sclk` in one read clears the buffer to zero, so a re-read returns 0x0000. A read that ends with fewer falls leaves the buffer intact.
- R10: `status_out` equals `sync_ok` when `status_sel` = 0. It equals the parity (1 = odd) latched at the last `field_tick` when `status_sel` = 1.
- R11: A field whose window sees no `cap_valid` transfers nothing, and the buffer keeps its previous content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_tick | input | 1 | One-cycle strobe at the start of a field |
| field_is_odd | input | 1 | Parity of the field starting at `field_tick` (1 = odd) |
| line_tick | input | 1 | One-cycle strobe at the start of each scan line |
| sync_ok | input | 1 | External sync-present flag |
| both_fields | input | 1 | 1 = capture in every field, 0 = even fields only |
| status_sel | input | 1 | 0 = route `sync_ok`, 1 = route field parity |
| cap_data | input | DATA_W | Sliced caption word |
| cap_valid | input | 1 | Strobe qualifying `cap_data` |
| rd_en_n | input | 1 | Host read enable, active low |
| rd_sclk | input | 1 | Host serial clock; bits advance on its falling edge |
| line21_pulse | output | 1 | Capture window for the caption line |
| status_out | output | 1 | Sync-present flag or field parity |
| rd_sdo | output | 1 | Serial read data |
| rd_sdo_oe | output | 1 | Drive enable for the serial data pin |

## Verification
On every cycle, the assertions check the following. The pulse rises only on a line tick, and only in an even field when the mode is even-only. It falls only on a line or field tick. The data pin stays undriven and low while the enable is high. The buffer stays frozen during a read, apart from its clear to zero. It loads a non-zero word only just after the pulse falls. The serial bit holds steady between host clock falls. Only the directed scenarios can show the rest: which word actually reaches the host, and in what bit order. They also cover the last-strobe-wins capture, the zero re-read after a full read, the intact buffer after a partial read, the discarded word when the enable is low at the transfer, and the routing of field parity to the status pin.

// File: rtl/cc_capture_port.sv
module cc_capture_port #(
  parameter int DATA_W   = 16,
  parameter int CAP_LINE = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_tick,
  input  logic              field_is_odd,
  input  logic              line_tick,
  input  logic              sync_ok,
  input  logic              both_fields,
  input  logic              status_sel,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              cap_valid,
  input  logic              rd_en_n,
  input  logic              rd_sclk,
  output logic              line21_pulse,
  output logic              status_out,
  output logic              rd_sdo,
  output logic              rd_sdo_oe
);
  localparam int LC_W = $clog2(CAP_LINE + 2);
  localparam int BC_W = $clog2(DATA_W + 1);
  localparam logic [LC_W-1:0] LINE_SAT = LC_W'(CAP_LINE + 1);
  localparam logic [LC_W-1:0] LINE_TRIG = LC_W'(CAP_LINE - 1);
  localparam logic [BC_W-1:0] BIT_LAST = BC_W'(DATA_W - 1);
  localparam logic [BC_W-1:0] BIT_SAT = BC_W'(DATA_W);

  logic [LC_W-1:0]   line_cnt;
  logic              odd_q;
  logic              pulse_q;
  logic              pulse_d;
  logic              have_new;
  logic              en_q;
  logic              sclk_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] buf_q;
  logic [DATA_W-1:0] shadow_q;
  logic [BC_W-1:0]   bcnt_q;

  wire field_ok   = both_fields | ~odd_q;
  wire pulse_fall = pulse_d & ~pulse_q;
  wire rd_start   = en_q & ~rd_en_n;
  wire rd_shift   = ~en_q & ~rd_en_n & sclk_q & ~rd_sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
      odd_q    <= 1'b0;
      pulse_q  <= 1'b0;
      pulse_d  <= 1'b0;
    end else begin
      pulse_d <= pulse_q;
      if (field_tick) begin
        line_cnt <= '0;
        odd_q    <= field_is_odd;
        pulse_q  <= 1'b0;
      end else if (line_tick) begin
        if (line_cnt != LINE_SAT) line_cnt <= line_cnt + 1'b1;
        pulse_q <= (line_cnt == LINE_TRIG) && field_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= '0;
      have_new <= 1'b0;
    end else if (pulse_fall) begin
      have_new <= 1'b0;
    end else if (pulse_q && cap_valid) begin
      hold_q   <= cap_data;
      have_new <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b1;
      sclk_q   <= 1'b0;
      buf_q    <= '0;
      shadow_q <= '0;
      bcnt_q   <= '0;
    end else begin
      en_q   <= rd_en_n;
      sclk_q <= rd_sclk;
      if (pulse_fall && have_new && rd_en_n) buf_q <= hold_q;
      if (rd_start) begin
        shadow_q <= buf_q;
        bcnt_q   <= '0;
      end else if (rd_shift) begin
        shadow_q <= shadow_q >> 1;
        if (bcnt_q != BIT_SAT) bcnt_q <= bcnt_q + 1'b1;
        if (bcnt_q == BIT_LAST) buf_q <= '0;
      end
    end
  end

  assign line21_pulse = pulse_q;
  assign status_out   = status_sel ? odd_q : sync_ok;
  assign rd_sdo_oe    = ~rd_en_n;
  assign rd_sdo       = ~rd_en_n & shadow_q[0];
endmodule

// File: rtl/cc_capture_port_chk.sv
module cc_capture_port_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              field_tick,
  input logic              line_tick,
  input logic              both_fields,
  input logic              rd_en_n,
  input logic              rd_sclk,
  input logic              line21_pulse,
  input logic              rd_sdo,
  input logic              rd_sdo_oe,
  input logic              odd_q,
  input logic [DATA_W-1:0] buf_q
);
  a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line21_pulse) |-> $past(line_tick));

  a_r3_even_only: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(line21_pulse) && !$past(both_fields)) |-> !odd_q);

  a_r3_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line21_pulse) |-> ($past(line_tick) || $past(field_tick)));

  a_r2_hiz_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_n |-> (!rd_sdo_oe && !rd_sdo));

  a_r7_buf_frozen_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rd_en_n) && !$stable(buf_q)) |-> (buf_q == '0));

  a_r6_load_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(buf_q) && buf_q != '0) |-> ($past(line21_pulse, 2) && !$past(line21_pulse)));

  a_r8_sdo_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_n && $past(!rd_en_n) && $past(!rd_en_n, 2) &&
     !($past(rd_sclk, 2) && !$past(rd_sclk))) |-> $stable(rd_sdo));
endmodule

bind cc_capture_port cc_capture_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .field_tick(field_tick), .line_tick(line_tick),
  .both_fields(both_fields), .rd_en_n(rd_en_n), .rd_sclk(rd_sclk),
  .line21_pulse(line21_pulse), .rd_sdo(rd_sdo), .rd_sdo_oe(rd_sdo_oe),
  .odd_q(odd_q), .buf_q(buf_q)
);

// File: tb/cc_capture_port_tb.sv
`timescale 1ns/1ps
module cc_capture_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic field_tick = 1'b0, field_is_odd = 1'b0, line_tick = 1'b0;
  logic sync_ok = 1'b0, both_fields = 1'b0, status_sel = 1'b0;
  logic [15:0] cap_data = '0;
  logic cap_valid = 1'b0, rd_en_n = 1'b1, rd_sclk = 1'b1;
  logic line21_pulse, status_out, rd_sdo, rd_sdo_oe;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cc_capture_port u_dut (
    .clk(clk), .rst_n(rst_n), .field_tick(field_tick), .field_is_odd(field_is_odd),
    .line_tick(line_tick), .sync_ok(sync_ok), .both_fields(both_fields),
    .status_sel(status_sel), .cap_data(cap_data), .cap_valid(cap_valid),
    .rd_en_n(rd_en_n), .rd_sclk(rd_sclk), .line21_pulse(line21_pulse),
    .status_out(status_out), .rd_sdo(rd_sdo), .rd_sdo_oe(rd_sdo_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick_line();
    @(negedge clk) line_tick = 1'b1;
    @(negedge clk) line_tick = 1'b0;
  endtask

  task automatic strobe(input logic [15:0] d);
    @(negedge clk) begin cap_valid = 1'b1; cap_data = d; end
    @(negedge clk) cap_valid = 1'b0;
  endtask

  // Runs one field up to the open window; returns the pulse level seen on line 21.
  task automatic open_window(input logic odd, output logic seen);
    @(negedge clk) begin field_tick = 1'b1; field_is_odd = odd; end
    @(negedge clk) field_tick = 1'b0;
    for (int i = 0; i < 21; i++) tick_line();
    seen = line21_pulse;
  endtask

  task automatic close_window();
    tick_line();
    cyc(3);
  endtask

  task automatic read_word(input int nbits, output logic [15:0] w);
    w = '0;
    @(negedge clk) rd_en_n = 1'b0;
    cyc(2);
    for (int i = 0; i < nbits; i++) begin
      w[i] = rd_sdo;
      @(negedge clk) rd_sclk = 1'b0;
      cyc(1);
      @(negedge clk) rd_sclk = 1'b1;
      cyc(1);
    end
    @(negedge clk) rd_en_n = 1'b1;
    cyc(2);
  endtask

  task automatic t_reset();
    logic [15:0] w;
    check("R1 pulse idle", {15'b0, line21_pulse}, 16'h0);
    check("R1 oe idle", {15'b0, rd_sdo_oe}, 16'h0);
    check("R2 sdo low when idle", {15'b0, rd_sdo}, 16'h0);
    @(negedge clk) rd_en_n = 1'b0;
    cyc(1);
    check("R2 oe while enabled", {15'b0, rd_sdo_oe}, 16'h1);
    @(negedge clk) rd_en_n = 1'b1;
    cyc(2);
    read_word(16, w);
    check("R1 empty buffer", w, 16'h0);
  endtask

  task automatic t_even_capture();
    logic seen; logic [15:0] w;
    both_fields = 1'b0;
    open_window(1'b0, seen);
    check("R3 pulse in even field", {15'b0, seen}, 16'h1);
    strobe(16'hA5C3);
    tick_line();
    check("R3 pulse falls next line", {15'b0, line21_pulse}, 16'h0);
    cyc(3);
    read_word(16, w);
    check("R6 R8 word read LSB first", w, 16'hA5C3);
    read_word(16, w);
    check("R9 re-read is zero", w, 16'h0);
  endtask

  task automatic t_odd_skipped();
    logic seen; logic [15:0] w;
    both_fields = 1'b0;
    open_window(1'b1, seen);
    check("R3 no pulse in odd field", {15'b0, seen}, 16'h0);
    strobe(16'h1234);
    close_window();
    read_word(16, w);
    check("R3 odd field not captured", w, 16'h0);
  endtask

  task automatic t_both_fields();
    logic seen; logic [15:0] w;
    both_fields = 1'b1;
    open_window(1'b1, seen);
    check("R4 pulse in odd field", {15'b0, seen}, 16'h1);
    strobe(16'h0F0F);
    close_window();
    read_word(16, w);
    check("R4 odd field captured", w, 16'h0F0F);
    both_fields = 1'b0;
  endtask

  task automatic t_capture_window();
    logic seen; logic [15:0] w;
    strobe(16'hFFFF);
    open_window(1'b0, seen);
    close_window();
    read_word(16, w);
    check("R11 no strobe in window, no transfer", w, 16'h0);
    open_window(1'b0, seen);
    strobe(16'h1111);
    strobe(16'h2222);
    close_window();
    strobe(16'h7777);
    read_word(16, w);
    check("R5 last strobe wins", w, 16'h2222);
  endtask

  task automatic t_keep_old();
    logic seen; logic [15:0] w;
    open_window(1'b0, seen);
    strobe(16'h3C3C);
    close_window();
    open_window(1'b0, seen);
    close_window();
    read_word(16, w);
    check("R11 buffer keeps old word", w, 16'h3C3C);
  endtask

  task automatic t_blocked();
    logic seen; logic [15:0] w;
    open_window(1'b0, seen);
    strobe(16'h5A5A);
    @(negedge clk) rd_en_n = 1'b0;
    close_window();
    @(negedge clk) rd_en_n = 1'b1;
    cyc(2);
    read_word(16, w);
    check("R7 transfer blocked while enabled", w, 16'h0);
  endtask

  task automatic t_partial();
    logic seen; logic [15:0] w;
    open_window(1'b0, seen);
    strobe(16'hBEEF);
    close_window();
    read_word(5, w);
    check("R8 partial read bits", w, 16'h000F);
    read_word(16, w);
    check("R9 partial read keeps buffer", w, 16'hBEEF);
    read_word(16, w);
    check("R9 zero after full read", w, 16'h0);
  endtask

  task automatic t_status();
    logic seen;
    status_sel = 1'b0; sync_ok = 1'b1;
    cyc(1);
    check("R10 sync flag routed", {15'b0, status_out}, 16'h1);
    status_sel = 1'b1;
    open_window(1'b1, seen);
    check("R10 odd parity routed", {15'b0, status_out}, 16'h1);
    close_window();
    open_window(1'b0, seen);
    check("R10 even parity routed", {15'b0, status_out}, 16'h0);
    close_window();
    status_sel = 1'b0; sync_ok = 1'b0;
    cyc(1);
    check("R10 sync flag low", {15'b0, status_out}, 16'h0);
  endtask

  initial begin
    cyc(5);
    @(negedge clk) rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_even_capture();
    t_odd_skipped();
    t_both_fields();
    t_capture_window();
    t_keep_old();
    t_blocked();
    t_partial();
    t_status();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule